// File: doc/BRIEF.md
# RGMII double-edge nibble adapter

This block sits between a byte-wide MAC datapath and a reduced-pin PHY link. The link moves each byte over a 4-bit bus and a single control line per direction by using both clock edges. On transmit it takes a byte with enable and error flags. It drives the nibble bus, the control line and a forwarded copy of the clock. On receive it captures the nibble bus and control line on both edges. It then rebuilds the byte with its valid and error flags.

The link speed is chosen with `speed`. At gigabit rate one full byte moves per clock. At the two slower rates both edges carry the same nibble, so a byte takes two cycles, low nibble first. The transmit side paces the MAC with `tx_req` and the receive side marks each finished byte with `rx_stb`. The double-rate I/O cells are modelled with rising-edge and falling-edge registers. The transmit output pins show the rising-edge half while the clock is high and the falling-edge half while it is low.

Transmit states: TX_FULL (gigabit, one byte per cycle), TX_LOW (slow rate: accept a byte and send its low nibble) and TX_HIGH (slow rate: send the held high nibble). Transitions: any state goes to TX_FULL when gigabit is selected. At slow rate, TX_FULL goes to TX_LOW, TX_LOW goes to TX_HIGH and TX_HIGH goes to TX_LOW. Receive states: RX_FULL (gigabit), RX_WAIT (waiting for a low nibble) and RX_HAVE (low nibble held). Transitions: any state goes to RX_FULL at gigabit. At slow rate, RX_FULL goes to RX_WAIT. RX_WAIT goes to RX_HAVE when the captured cycle is valid and otherwise stays. RX_HAVE always returns to RX_WAIT. Reset enters TX_FULL/RX_FULL at gigabit and TX_LOW/RX_WAIT otherwise.

Top module: `rgmii_ddr_adapter`

## Requirements
- R1: With speed[1]=1 (gigabit, encoding 2'b10), a byte on `tx_data` sampled at rising edge k appears on `txd` as bits [3:0] while the clock is high after edge k and as bits [7:4] while the clock is low in that same cycle; `txc` follows the clock.
- R2: At gigabit, `tx_ctl` carries `tx_en` while the clock is high and `tx_en` XOR `tx_er` while it is low, for the byte sampled at the same edge; `tx_req` stays high.
- R3: At slow rate (speed 2'b01 for 100 Mb/s), `tx_req` is high every second cycle. The byte present in a `tx_req` cycle is taken at the closing rising edge. Its low nibble is sent on both clock phases of the next cycle and its high nibble on both phases of the cycle after that, with the same control pair in both cycles. Inputs in cycles with `tx_req` low have no effect on the outputs.
- R4: At gigabit, the receive nibbles captured at rising edge k and the falling edge after it form `rx_data` = {falling nibble, rising nibble}. They appear after rising edge k+1 with `rx_dv` = rising control bit, `rx_er` = rising XOR falling control bit, and `rx_stb` high.
- R5: A received cycle whose control line is low at the rising edge and high at the falling edge is a non-data condition: `rx_dv`, `rx_er` and `rx_stb` go low and `rx_data` keeps its last value.
- R6: A received cycle with the control line low on both edges gives `rx_dv` and `rx_stb` low.
- R7: At slow rate the first valid received cycle supplies the low nibble and the next one the high nibble. `rx_stb` pulses after the rising edge that follows the second cycle and never pulses in two consecutive cycles.
- R8: At slow rate `rx_er` for an assembled byte is the OR of the error indications of its two cycles.
- R9: At slow rate, if valid drops after only a low nibble, that nibble is discarded, no byte is emitted, `rx_dv` goes low, and nibble alignment restarts with the next valid cycle.
- R10: While `rst` is high at a rising edge, `txd` and `tx_ctl` are low on both phases from that cycle on, and `rx_data`, `rx_dv`, `rx_er` and `rx_stb` are low.
- R11: Speed 2'b00 (10 Mb/s) behaves the same as 2'b01 at the cycle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit interface clock |
| rst | input | 1 | Synchronous reset, active high |
| speed | input | 2 | Link speed: 2'b10 gigabit, 2'b01 100 Mb/s, 2'b00 10 Mb/s |
| tx_data | input | 8 | Transmit byte from the MAC |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error |
| tx_req | output | 1 | High in cycles whose transmit byte is taken |
| txc | output | 1 | Forwarded transmit clock |
| txd | output | 4 | Double-rate transmit nibble bus |
| tx_ctl | output | 1 | Double-rate transmit control line |
| rx_clk | input | 1 | Receive interface clock |
| rxd | input | 4 | Double-rate receive nibble bus |
| rx_ctl | input | 1 | Double-rate receive control line |
| rx_data | output | 8 | Rebuilt receive byte |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_stb | output | 1 | One-cycle pulse for each rebuilt byte |

## Verification
A transmitted byte shows up one rising edge after it is sampled. Its first half is checked shortly after that edge and its second half shortly after the following falling edge. A received gigabit cycle reaches the byte outputs one full cycle after its own rising edge. The bench drives the rising-edge half of each receive cycle before the edge and the falling-edge half after it. It then compares the receive outputs in the next step against the expected result of the previous step. At slow rate the strobe is expected one edge after the high-nibble cycle, and each cycle in between is also checked, so a misaligned or doubled strobe is caught.

// File: rtl/rgmii_pkg.sv
package rgmii_pkg;

    typedef enum logic [1:0] {
        TX_FULL = 2'd0,
        TX_LOW  = 2'd1,
        TX_HIGH = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_FULL = 2'd0,
        RX_WAIT = 2'd1,
        RX_HAVE = 2'd2
    } rx_state_e;

    localparam logic [1:0] SPD_10   = 2'b00;
    localparam logic [1:0] SPD_100  = 2'b01;
    localparam logic [1:0] SPD_1000 = 2'b10;

    // gigabit whenever the upper speed bit is set
    function automatic logic is_gig(input logic [1:0] spd);
        return (spd == SPD_1000) || (spd == 2'b11);
    endfunction

endpackage

// File: rtl/rgmii_tx_path.sv
module rgmii_tx_path
    import rgmii_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           speed,
    input  logic [2*NIB_W-1:0]   tx_data,
    input  logic                 tx_en,
    input  logic                 tx_er,
    output logic                 tx_req,
    output logic                 txc,
    output logic [NIB_W-1:0]     txd,
    output logic                 tx_ctl
);
    localparam int BYTE_W = 2 * NIB_W;

    tx_state_e            state, nxt;
    logic [NIB_W-1:0]     rise_d, fall_d, fall_dq;
    logic                 rise_c, fall_c, fall_cq;
    logic [BYTE_W-1:0]    hold;
    logic                 hold_en, hold_er;
    logic                 gig;

    assign gig = is_gig(speed);

    always_comb begin
        nxt = state;
        unique case (state)
            TX_FULL: nxt = gig ? TX_FULL : TX_LOW;
            TX_LOW:  nxt = gig ? TX_FULL : TX_HIGH;
            TX_HIGH: nxt = gig ? TX_FULL : TX_LOW;
            default: nxt = TX_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= gig ? TX_FULL : TX_LOW;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_d  <= '0;
            fall_d  <= '0;
            rise_c  <= 1'b0;
            fall_c  <= 1'b0;
            hold    <= '0;
            hold_en <= 1'b0;
            hold_er <= 1'b0;
        end else begin
            unique case (state)
                TX_FULL: begin
                    rise_d <= tx_data[NIB_W-1:0];
                    fall_d <= tx_data[BYTE_W-1:NIB_W];
                    rise_c <= tx_en;
                    fall_c <= tx_en ^ tx_er;
                end
                TX_LOW: begin
                    hold    <= tx_data;
                    hold_en <= tx_en;
                    hold_er <= tx_er;
                    rise_d  <= tx_data[NIB_W-1:0];
                    fall_d  <= tx_data[NIB_W-1:0];
                    rise_c  <= tx_en;
                    fall_c  <= tx_en ^ tx_er;
                end
                TX_HIGH: begin
                    rise_d <= hold[BYTE_W-1:NIB_W];
                    fall_d <= hold[BYTE_W-1:NIB_W];
                    rise_c <= hold_en;
                    fall_c <= hold_en ^ hold_er;
                end
                default: begin
                    rise_d <= '0;
                    fall_d <= '0;
                    rise_c <= 1'b0;
                    fall_c <= 1'b0;
                end
            endcase
        end
    end

    // falling-edge half of the output cell
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_dq <= '0;
            fall_cq <= 1'b0;
        end else begin
            fall_dq <= fall_d;
            fall_cq <= fall_c;
        end
    end

    assign tx_req = (state != TX_HIGH);
    assign txc    = clk;
    assign txd    = clk ? rise_d : fall_dq;
    assign tx_ctl = clk ? rise_c : fall_cq;

    AST_TX_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
        (!gig && $past(!gig) && $past(!gig, 2) && $past(tx_req) && !$past(rst))
        |-> !tx_req) else $error("tx_req high twice at slow rate"); // R3

    AST_TX_RST_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rise_d == '0 && !rise_c)) else $error("tx not cleared"); // R10

endmodule

// File: rtl/rgmii_rx_path.sv
module rgmii_rx_path
    import rgmii_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 rx_clk,
    input  logic                 rst,
    input  logic [1:0]           speed,
    input  logic [NIB_W-1:0]     rxd,
    input  logic                 rx_ctl,
    output logic [2*NIB_W-1:0]   rx_data,
    output logic                 rx_dv,
    output logic                 rx_er,
    output logic                 rx_stb
);
    rx_state_e            state, nxt;
    logic [NIB_W-1:0]     r_d, f_d, lo_hold;
    logic                 r_c, f_c, er_hold;
    logic                 line_dv, line_er, gig;

    assign gig     = is_gig(speed);
    assign line_dv = r_c;
    assign line_er = r_c ^ f_c;

    // input cell: rising half and falling half
    always_ff @(posedge rx_clk) begin
        if (rst) begin
            r_d <= '0;
            r_c <= 1'b0;
        end else begin
            r_d <= rxd;
            r_c <= rx_ctl;
        end
    end

    always_ff @(negedge rx_clk) begin
        if (rst) begin
            f_d <= '0;
            f_c <= 1'b0;
        end else begin
            f_d <= rxd;
            f_c <= rx_ctl;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_FULL: nxt = gig ? RX_FULL : RX_WAIT;
            RX_WAIT: nxt = gig ? RX_FULL : (line_dv ? RX_HAVE : RX_WAIT);
            RX_HAVE: nxt = gig ? RX_FULL : RX_WAIT;
            default: nxt = RX_WAIT;
        endcase
    end

    always_ff @(posedge rx_clk) begin
        if (rst) state <= gig ? RX_FULL : RX_WAIT;
        else     state <= nxt;
    end

    always_ff @(posedge rx_clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_dv   <= 1'b0;
            rx_er   <= 1'b0;
            rx_stb  <= 1'b0;
            lo_hold <= '0;
            er_hold <= 1'b0;
        end else begin
            unique case (state)
                RX_FULL: begin
                    rx_stb <= line_dv;
                    rx_dv  <= line_dv;
                    rx_er  <= line_dv & line_er;
                    if (line_dv) rx_data <= {f_d, r_d};
                end
                RX_WAIT: begin
                    rx_stb <= 1'b0;
                    if (line_dv) begin
                        lo_hold <= r_d;
                        er_hold <= line_er;
                    end else begin
                        rx_dv <= 1'b0;
                        rx_er <= 1'b0;
                    end
                end
                RX_HAVE: begin
                    rx_stb <= line_dv;
                    rx_dv  <= line_dv;
                    rx_er  <= line_dv & (er_hold | line_er);
                    if (line_dv) rx_data <= {r_d, lo_hold};
                end
                default: rx_stb <= 1'b0;
            endcase
        end
    end

    AST_RX_NODATA: assert property (@(posedge rx_clk) disable iff (rst)
        (gig && $stable(speed) && !r_c && f_c) |=> (!rx_stb && !rx_dv))
        else $error("non-data cycle emitted a byte"); // R5

    AST_RX_STB_GAP: assert property (@(posedge rx_clk) disable iff (rst)
        (!gig && $past(!gig) && $past(!gig, 2) && $past(rx_stb) && !$past(rst))
        |-> !rx_stb) else $error("rx_stb in consecutive cycles"); // R7

    AST_RX_STB_DV: assert property (@(posedge rx_clk) disable iff (rst)
        rx_stb |-> rx_dv) else $error("strobe without valid"); // R4

endmodule

// File: rtl/rgmii_ddr_adapter.sv
module rgmii_ddr_adapter #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           speed,
    input  logic [2*NIB_W-1:0]   tx_data,
    input  logic                 tx_en,
    input  logic                 tx_er,
    output logic                 tx_req,
    output logic                 txc,
    output logic [NIB_W-1:0]     txd,
    output logic                 tx_ctl,
    input  logic                 rx_clk,
    input  logic [NIB_W-1:0]     rxd,
    input  logic                 rx_ctl,
    output logic [2*NIB_W-1:0]   rx_data,
    output logic                 rx_dv,
    output logic                 rx_er,
    output logic                 rx_stb
);

    rgmii_tx_path #(.NIB_W(NIB_W)) tx_i (
        .clk     (clk),
        .rst     (rst),
        .speed   (speed),
        .tx_data (tx_data),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .tx_req  (tx_req),
        .txc     (txc),
        .txd     (txd),
        .tx_ctl  (tx_ctl)
    );

    rgmii_rx_path #(.NIB_W(NIB_W)) rx_i (
        .rx_clk  (rx_clk),
        .rst     (rst),
        .speed   (speed),
        .rxd     (rxd),
        .rx_ctl  (rx_ctl),
        .rx_data (rx_data),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .rx_stb  (rx_stb)
    );

endmodule

// File: tb/rgmii_ddr_adapter_tb_top.sv
module rgmii_ddr_adapter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] speed;
    logic [7:0] tx_data;
    logic       tx_en, tx_er;
    logic       tx_req, txc, tx_ctl;
    logic [3:0] txd;
    logic [3:0] rxd;
    logic       rx_ctl;
    logic [7:0] rx_data;
    logic       rx_dv, rx_er, rx_stb;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rgmii_ddr_adapter dut_i (
        .clk(clk), .rst(rst), .speed(speed),
        .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er),
        .tx_req(tx_req), .txc(txc), .txd(txd), .tx_ctl(tx_ctl),
        .rx_clk(clk), .rxd(rxd), .rx_ctl(rx_ctl),
        .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er), .rx_stb(rx_stb)
    );

    // observations from the last step
    logic       o_req, o_rdv, o_rer, o_rstb, o_tc_h, o_tc_l;
    logic [7:0] o_rdata;
    logic [3:0] o_td_h, o_td_l;

    // {tx byte, en, er, rx byte, ctl rise, ctl fall}
    localparam logic [19:0] VEC [8] = '{
        {8'hA5, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1},
        {8'h5A, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b1, 8'h77, 1'b0, 1'b1},
        {8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b1},
        {8'h7E, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1},
        {8'h0F, 1'b1, 1'b0, 8'hF0, 1'b1, 1'b1},
        {8'h99, 1'b1, 1'b0, 8'h66, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic step(input logic [7:0] tb, input logic te, input logic tr,
                        input logic [3:0] rr, input logic [3:0] rf,
                        input logic cr, input logic cf);
        o_req   = tx_req;
        tx_data = tb;
        tx_en   = te;
        tx_er   = tr;
        rxd     = rr;
        rx_ctl  = cr;
        @(posedge clk); #1;
        o_rdata = rx_data;
        o_rdv   = rx_dv;
        o_rer   = rx_er;
        o_rstb  = rx_stb;
        o_td_h  = txd;
        o_tc_h  = tx_ctl;
        rxd     = rf;
        rx_ctl  = cf;
        @(negedge clk); #1;
        o_td_l  = txd;
        o_tc_l  = tx_ctl;
    endtask

    task automatic do_reset(input logic [1:0] spd);
        @(negedge clk); #1;
        speed = spd;
        rst = 1'b1;
        tx_data = 8'hFF; tx_en = 1'b1; tx_er = 1'b1;
        rxd = 4'hF; rx_ctl = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pe_data, hd, tb, rb;
        logic       pe_dv, pe_er, pe_stb, te, tr, cr, cf;
        string      tag;

        rst = 1'b1; speed = 2'b10;
        tx_data = '0; tx_en = 0; tx_er = 0; rxd = '0; rx_ctl = 0;

        // reset state, R10
        @(negedge clk); #1;
        tx_data = 8'hFF; tx_en = 1'b1; tx_er = 1'b1; rxd = 4'hF; rx_ctl = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "txd high phase", {4'h0, txd}, 8'h00);
        chk("R10", "tx_ctl high phase", {7'h0, tx_ctl}, 8'h00);
        chk("R10", "rx_data", rx_data, 8'h00);
        chk("R10", "rx_dv/er/stb", {5'h0, rx_dv, rx_er, rx_stb}, 8'h00);
        @(negedge clk); #1;
        chk("R10", "txd low phase", {4'h0, txd}, 8'h00);
        chk("R10", "tx_ctl low phase", {7'h0, tx_ctl}, 8'h00);
        rst = 1'b0;

        // gigabit table, R1 R2 R4 R5 R6
        pe_data = 8'h00; pe_dv = 0; pe_er = 0; pe_stb = 0; hd = 8'h00;
        tag = "R6";
        for (int i = 0; i < 8; i++) begin
            tb = VEC[i][19:12]; te = VEC[i][11]; tr = VEC[i][10];
            rb = VEC[i][9:2];   cr = VEC[i][1];  cf = VEC[i][0];
            step(tb, te, tr, rb[3:0], rb[7:4], cr, cf);
            chk(tag, "rx_data", o_rdata, pe_data);
            chk(tag, "rx_dv/er/stb", {5'h0, o_rdv, o_rer, o_rstb}, {5'h0, pe_dv, pe_er, pe_stb});
            chk("R1", "txd high phase", {4'h0, o_td_h}, {4'h0, tb[3:0]});
            chk("R1", "txd low phase", {4'h0, o_td_l}, {4'h0, tb[7:4]});
            chk("R2", "tx_ctl phases", {6'h0, o_tc_h, o_tc_l}, {6'h0, te, te ^ tr});
            chk("R2", "tx_req", {7'h0, o_req}, 8'h01);
            if (cr) begin
                hd = rb; pe_dv = 1; pe_er = cr ^ cf; pe_stb = 1; tag = "R4";
            end else begin
                pe_dv = 0; pe_er = 0; pe_stb = 0;
                tag = cf ? "R5" : "R6";
            end
            pe_data = hd;
        end
        step(8'h00, 0, 0, 4'h0, 4'h0, 0, 0);
        chk(tag, "rx_data", o_rdata, pe_data);
        chk(tag, "rx_dv/er/stb", {5'h0, o_rdv, o_rer, o_rstb}, {5'h0, pe_dv, pe_er, pe_stb});

        // 100 Mb/s, R3 R7 R8 R9
        do_reset(2'b01);
        step(8'h4B, 1, 0, 4'h3, 4'h3, 1, 1);
        chk("R3", "tx_req accept cycle", {7'h0, o_req}, 8'h01);
        chk("R3", "low nibble both phases", {o_td_h, o_td_l}, 8'hBB);
        chk("R3", "ctl first cycle", {6'h0, o_tc_h, o_tc_l}, 8'h03);
        chk("R7", "no strobe yet", {7'h0, o_rstb}, 8'h00);
        step(8'hEE, 0, 1, 4'hA, 4'hA, 1, 1);
        chk("R3", "tx_req idle cycle", {7'h0, o_req}, 8'h00);
        chk("R3", "high nibble both phases", {o_td_h, o_td_l}, 8'h44);
        chk("R3", "ctl second cycle", {6'h0, o_tc_h, o_tc_l}, 8'h03);
        chk("R7", "no strobe after low nibble", {7'h0, o_rstb}, 8'h00);
        step(8'hD2, 1, 1, 4'h5, 4'h5, 1, 0);
        chk("R3", "tx_req again", {7'h0, o_req}, 8'h01);
        chk("R3", "second byte low nibble", {o_td_h, o_td_l}, 8'h22);
        chk("R3", "ctl with error", {6'h0, o_tc_h, o_tc_l}, 8'h02);
        chk("R7", "strobe/dv/er", {5'h0, o_rdv, o_rer, o_rstb}, 8'h05);
        chk("R7", "assembled byte", o_rdata, 8'hA3);
        step(8'h11, 0, 0, 4'h9, 4'h9, 1, 1);
        chk("R3", "second byte high nibble", {o_td_h, o_td_l}, 8'hDD);
        chk("R7", "no strobe next cycle", {7'h0, o_rstb}, 8'h00);
        step(8'h00, 0, 0, 4'h6, 4'h6, 1, 1);
        chk("R8", "strobe with error", {5'h0, o_rdv, o_rer, o_rstb}, 8'h07);
        chk("R8", "assembled byte", o_rdata, 8'h95);
        step(8'h00, 0, 0, 4'h0, 4'h0, 0, 0);
        chk("R9", "no strobe on low nibble", {7'h0, o_rstb}, 8'h00);
        step(8'h00, 0, 0, 4'h1, 4'h1, 1, 1);
        chk("R9", "half byte dropped", {5'h0, o_rdv, o_rer, o_rstb}, 8'h00);
        chk("R9", "data held", o_rdata, 8'h95);
        step(8'h00, 0, 0, 4'h8, 4'h8, 1, 1);
        chk("R9", "no strobe after new low", {7'h0, o_rstb}, 8'h00);
        step(8'h00, 0, 0, 4'h0, 4'h0, 0, 0);
        chk("R9", "realigned strobe", {5'h0, o_rdv, o_rer, o_rstb}, 8'h05);
        chk("R9", "realigned byte", o_rdata, 8'h81);

        // 10 Mb/s, R11
        do_reset(2'b00);
        step(8'hC7, 1, 0, 4'h2, 4'h2, 1, 1);
        chk("R11", "tx_req accept", {7'h0, o_req}, 8'h01);
        chk("R11", "low nibble both phases", {o_td_h, o_td_l}, 8'h77);
        step(8'h00, 0, 0, 4'hE, 4'hE, 1, 1);
        chk("R11", "tx_req idle", {7'h0, o_req}, 8'h00);
        chk("R11", "high nibble both phases", {o_td_h, o_td_l}, 8'hCC);
        step(8'h00, 0, 0, 4'h0, 4'h0, 0, 0);
        chk("R11", "assembled byte", o_rdata, 8'hE2);
        chk("R11", "strobe", {7'h0, o_rstb}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule